// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects up to 96 level-sensitive interrupt sources and turns them into an interrupt line for each of two CPUs, plus a combinational vector that names the winning source. Sources arrive on three 32-bit groups:

- a primary-low group, vectors 0 to 31;
- a primary-high group, vectors 32 to 63;
- a group of general-purpose pins, vectors 64 to 95.

The pins go into a sticky pin-cause register. That register is summarised into four bits of the primary-high cause, so a pin interrupt is resolved in two steps. The first step picks the summary bit. The second step picks the pin from the pin-cause register.

Software reaches the masks and the pin-cause register through a single-cycle register port. Writes take effect at the next clock edge. Reads are combinational. CPU0 takes every allowed source. CPU1 is raised only by the doorbell source and has its own low mask. The interrupt service path reads the vector outputs, which reflect the current sources and register state in the same cycle.

Top module: `cascade_intc`

## Requirements
- R1: The vector number is the low-cause bit index for the primary-low group. It is 32 plus the bit index for the primary-high group, and 64 plus the pin index for pin sources.
- R2: Primary sources are pending exactly while their inputs are high. A high pin input sets its pin-cause bit at the next clock edge, and the bit stays set while the pin stays high.
- R3: Only primary-low bits in 0x3DFFFFFE can win for CPU0. Bits 0, 25, 30 and 31 never produce a vector or raise CPU0.
- R4: Only primary-high bits in 0x1F0003F7 can win. Bits 3, 10 to 23 and 29 to 31 never produce a vector or raise CPU0.
- R5: Reset state:
  - the CPU0 high mask is 0x0F000000;
  - the CPU0 low mask, the CPU1 low mask, the pin mask and the pin cause are all zero;
  - no vector is valid.
- R6: Selection is ordered, and within one register the lowest-numbered enabled pending bit wins:
  - an enabled allowed primary-low bit beats any primary-high bit;
  - an enabled allowed primary-high bit beats any pin.
- R7: If a winning primary-high bit is a summary bit (24 to 27) and no enabled pin-cause bit is set, vec_spurious_o is 1 and vec_valid_o is 0. The two flags are never both 1.
- R8: A write to the pin-cause register at 0x14 clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R9: cpu1_irq_o is 1 exactly when primary-low bit 28 (the doorbell) is high and bit 28 of the CPU1 low mask is set. No other source or mask bit affects it.
- R10: The register map is:
  - 0x00: primary-low cause, read-only;
  - 0x04: primary-high cause, read-only;
  - 0x08: CPU0 low mask;
  - 0x0C: CPU0 high mask;
  - 0x10: CPU1 low mask;
  - 0x14: pin cause;
  - 0x18: pin mask;
  - any other address reads as zero.

  A set mask bit enables its source and a clear bit disables it. The mask registers read back the last value written.
- R11: Primary-high cause bit 24+k reads as the OR of pin-cause bits 8k to 8k+7, for k = 0 to 3. The src_hi_i inputs at bits 24 to 27 are ignored.
- R12: cpu0_irq_o is 1 exactly when vec_valid_o or vec_spurious_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_lo_i | input | 32 | Primary-low level sources |
| src_hi_i | input | 32 | Primary-high level sources (bits 24 to 27 unused) |
| gpp_pin_i | input | 32 | General-purpose pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cpu0_irq_o | output | 1 | CPU0 interrupt request |
| cpu1_irq_o | output | 1 | CPU1 doorbell interrupt request |
| vec_valid_o | output | 1 | vec_num_o names a pending source |
| vec_spurious_o | output | 1 | A summary bit won with no enabled pin cause |
| vec_num_o | output | 7 | Winning vector number, 0 to 95 |

## Verification
The assertions take for granted that the source and pin inputs are two-valued and change only between clock edges. They also assume that a register write is a one-cycle strobe, with the address and data stable around the edge. The stimulus drives every input on the falling edge. It holds the inputs for a full cycle and samples shortly after the rising edge. The random source patterns are thinned by ANDing several draws, so that ties and single-bit winners both occur. Register writes use only the mapped addresses, except for one read of an unmapped address.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CAUSE_LO = 5'h00,
    ADDR_CAUSE_HI = 5'h04,
    ADDR_MASK0_LO = 5'h08,
    ADDR_MASK0_HI = 5'h0C,
    ADDR_MASK1_LO = 5'h10,
    ADDR_GPP_CAUSE = 5'h14,
    ADDR_GPP_MASK = 5'h18
  } reg_addr_e;
endpackage

// File: rtl/intc_prio_find.sv
module intc_prio_find #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the lowest set bit is the last assignment.
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter logic [REG_W-1:0] HI_MASK_RST = 32'h0F00_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  gpp_pin_i,
  output logic [REG_W-1:0]  mask0_lo_o,
  output logic [REG_W-1:0]  mask0_hi_o,
  output logic [REG_W-1:0]  mask1_lo_o,
  output logic [REG_W-1:0]  gpp_cause_o,
  output logic [REG_W-1:0]  gpp_mask_o
);
  logic [REG_W-1:0] mask0_lo_q, mask0_hi_q, mask1_lo_q, gpp_cause_q, gpp_mask_q;
  logic [REG_W-1:0] gpp_keep;
  logic             wr_gpp_cause;

  assign wr_gpp_cause = we_i && (addr_i == ADDR_GPP_CAUSE);
  assign gpp_keep     = wr_gpp_cause ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask0_lo_q  <= '0;
      mask0_hi_q  <= HI_MASK_RST;
      mask1_lo_q  <= '0;
      gpp_cause_q <= '0;
      gpp_mask_q  <= '0;
    end else begin
      if (we_i && addr_i == ADDR_MASK0_LO) mask0_lo_q <= wdata_i;
      if (we_i && addr_i == ADDR_MASK0_HI) mask0_hi_q <= wdata_i;
      if (we_i && addr_i == ADDR_MASK1_LO) mask1_lo_q <= wdata_i;
      if (we_i && addr_i == ADDR_GPP_MASK) gpp_mask_q <= wdata_i;
      // Write-zero-to-clear, then re-set by pins still at level.
      gpp_cause_q <= (gpp_cause_q & gpp_keep) | gpp_pin_i;
    end
  end

  assign mask0_lo_o  = mask0_lo_q;
  assign mask0_hi_o  = mask0_hi_q;
  assign mask1_lo_o  = mask1_lo_q;
  assign gpp_cause_o = gpp_cause_q;
  assign gpp_mask_o  = gpp_mask_q;

  AST_GPP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_gpp_cause |=> ((gpp_cause_q & $past(gpp_cause_q)) == $past(gpp_cause_q))); // R8
  AST_GPP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gpp_pin_i) |=> ((gpp_cause_q & $past(gpp_pin_i)) == $past(gpp_pin_i))); // R2
  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MASK0_HI) |=> (mask0_hi_q == $past(wdata_i))); // R10
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
  import intc_pkg::*;
#(
  parameter logic [REG_W-1:0] LO_ALLOW     = 32'h3DFF_FFFE,
  parameter logic [REG_W-1:0] HI_ALLOW     = 32'h1F00_03F7,
  parameter int unsigned      GPP_SUM_LSB  = 24,
  parameter int unsigned      GPP_GROUPS   = 4,
  localparam int unsigned     IW           = $clog2(REG_W),
  localparam int unsigned     VEC_W        = $clog2(3 * REG_W)
) (
  input  logic [REG_W-1:0] cause_lo_i,
  input  logic [REG_W-1:0] cause_hi_i,
  input  logic [REG_W-1:0] gpp_cause_i,
  input  logic [REG_W-1:0] mask_lo_i,
  input  logic [REG_W-1:0] mask_hi_i,
  input  logic [REG_W-1:0] gpp_mask_i,
  output logic             valid_o,
  output logic             spurious_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [IW-1:0] SUM_FIRST = IW'(GPP_SUM_LSB);
  localparam logic [IW-1:0] SUM_LAST  = IW'(GPP_SUM_LSB + GPP_GROUPS - 1);

  logic [REG_W-1:0] lo_req, hi_req, gp_req;
  logic             lo_f, hi_f, gp_f;
  logic [IW-1:0]    lo_idx, hi_idx, gp_idx;

  assign lo_req = cause_lo_i & LO_ALLOW & mask_lo_i;
  assign hi_req = cause_hi_i & HI_ALLOW & mask_hi_i;
  assign gp_req = gpp_cause_i & gpp_mask_i;

  intc_prio_find #(.W(REG_W)) u_find_lo (.req_i(lo_req), .found_o(lo_f), .idx_o(lo_idx));
  intc_prio_find #(.W(REG_W)) u_find_hi (.req_i(hi_req), .found_o(hi_f), .idx_o(hi_idx));
  intc_prio_find #(.W(REG_W)) u_find_gp (.req_i(gp_req), .found_o(gp_f), .idx_o(gp_idx));

  always_comb begin
    valid_o    = 1'b0;
    spurious_o = 1'b0;
    vec_o      = '0;
    if (lo_f) begin
      valid_o = 1'b1;
      vec_o   = VEC_W'(lo_idx);
    end else if (hi_f) begin
      if (hi_idx >= SUM_FIRST && hi_idx <= SUM_LAST) begin
        if (gp_f) begin
          valid_o = 1'b1;
          vec_o   = VEC_W'(2 * REG_W) + VEC_W'(gp_idx);
        end else begin
          spurious_o = 1'b1;
        end
      end else begin
        valid_o = 1'b1;
        vec_o   = VEC_W'(REG_W) + VEC_W'(hi_idx);
      end
    end
  end

  always_comb begin
    AST_FLAGS_EXCLUSIVE: assert (!(valid_o && spurious_o)); // R7
    AST_GPP_ONLY_VIA_SUMMARY: assert (!(valid_o && vec_o >= VEC_W'(2 * REG_W)) || (hi_f && !lo_f)); // R6
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter logic [REG_W-1:0] LO_ALLOW     = 32'h3DFF_FFFE,
  parameter logic [REG_W-1:0] HI_ALLOW     = 32'h1F00_03F7,
  parameter logic [REG_W-1:0] HI_MASK_RST  = 32'h0F00_0000,
  parameter int unsigned      GPP_SUM_LSB  = 24,
  parameter int unsigned      GPP_GROUPS   = 4,
  parameter int unsigned      DOORBELL_BIT = 28,
  localparam int unsigned     GRP_W        = REG_W / GPP_GROUPS,
  localparam int unsigned     VEC_W        = $clog2(3 * REG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  src_lo_i,
  input  logic [REG_W-1:0]  src_hi_i,
  input  logic [REG_W-1:0]  gpp_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              cpu0_irq_o,
  output logic              cpu1_irq_o,
  output logic              vec_valid_o,
  output logic              vec_spurious_o,
  output logic [VEC_W-1:0]  vec_num_o
);
  logic [REG_W-1:0]      mask0_lo, mask0_hi, mask1_lo, gpp_cause, gpp_mask;
  logic [REG_W-1:0]      cause_hi;
  logic [GPP_GROUPS-1:0] gpp_sum;

  intc_regs #(.HI_MASK_RST(HI_MASK_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .gpp_pin_i  (gpp_pin_i),
    .mask0_lo_o (mask0_lo),
    .mask0_hi_o (mask0_hi),
    .mask1_lo_o (mask1_lo),
    .gpp_cause_o(gpp_cause),
    .gpp_mask_o (gpp_mask)
  );

  for (genvar g = 0; g < GPP_GROUPS; g++) begin : g_sum
    assign gpp_sum[g] = |gpp_cause[g*GRP_W +: GRP_W];
  end

  always_comb begin
    cause_hi = src_hi_i;
    cause_hi[GPP_SUM_LSB +: GPP_GROUPS] = gpp_sum;
  end

  intc_resolve #(
    .LO_ALLOW   (LO_ALLOW),
    .HI_ALLOW   (HI_ALLOW),
    .GPP_SUM_LSB(GPP_SUM_LSB),
    .GPP_GROUPS (GPP_GROUPS)
  ) u_resolve (
    .cause_lo_i (src_lo_i),
    .cause_hi_i (cause_hi),
    .gpp_cause_i(gpp_cause),
    .mask_lo_i  (mask0_lo),
    .mask_hi_i  (mask0_hi),
    .gpp_mask_i (gpp_mask),
    .valid_o    (vec_valid_o),
    .spurious_o (vec_spurious_o),
    .vec_o      (vec_num_o)
  );

  assign cpu0_irq_o = vec_valid_o | vec_spurious_o;
  assign cpu1_irq_o = src_lo_i[DOORBELL_BIT] & mask1_lo[DOORBELL_BIT];

  always_comb begin
    case (reg_addr_i)
      ADDR_CAUSE_LO:  reg_rdata_o = src_lo_i;
      ADDR_CAUSE_HI:  reg_rdata_o = cause_hi;
      ADDR_MASK0_LO:  reg_rdata_o = mask0_lo;
      ADDR_MASK0_HI:  reg_rdata_o = mask0_hi;
      ADDR_MASK1_LO:  reg_rdata_o = mask1_lo;
      ADDR_GPP_CAUSE: reg_rdata_o = gpp_cause;
      ADDR_GPP_MASK:  reg_rdata_o = gpp_mask;
      default:        reg_rdata_o = '0;
    endcase
  end

  AST_CPU1_DOORBELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu1_irq_o |-> src_lo_i[DOORBELL_BIT]); // R9
  AST_LO_VEC_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_num_o < VEC_W'(REG_W)) |-> src_lo_i[vec_num_o[$clog2(REG_W)-1:0]]); // R1
  AST_SPURIOUS_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_spurious_o |-> (|gpp_sum) && ((gpp_cause & gpp_mask) == '0)); // R7
endmodule

// File: tb/cascade_intc_test.sv
`timescale 1ns/1ps
module cascade_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, pin = '0, wdata = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] rdata;
  logic        cpu0, cpu1, vvalid, vspur;
  logic [6:0]  vnum;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the architected state
  logic [31:0] m0lo = '0, m0hi = 32'h0F00_0000, m1lo = '0, gmask = '0, gcause = '0;

  always #2 clk = ~clk;

  cascade_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .src_lo_i(src_lo), .src_hi_i(src_hi),
    .gpp_pin_i(pin), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu0_irq_o(cpu0), .cpu1_irq_o(cpu1),
    .vec_valid_o(vvalid), .vec_spurious_o(vspur), .vec_num_o(vnum)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_view(logic [31:0] h, logic [31:0] gc);
    logic [31:0] r = h;
    for (int k = 0; k < 4; k++) r[24+k] = |gc[8*k +: 8];
    return r;
  endfunction

  function automatic int lowest(logic [31:0] v);
    int idx = -1;
    for (int i = 31; i >= 0; i--) if (v[i]) idx = i;
    return idx;
  endfunction

  function automatic logic [31:0] read_model(logic [4:0] a);
    case (a)
      5'h00: return src_lo;
      5'h04: return hi_view(src_hi, gcause);
      5'h08: return m0lo;
      5'h0C: return m0hi;
      5'h10: return m1lo;
      5'h14: return gcause;
      5'h18: return gmask;
      default: return '0;
    endcase
  endfunction

  task automatic check_outputs(string tag);
    int lo_i, hi_i, gp_i;
    logic e_valid = 0, e_spur = 0;
    int e_vec = 0;
    lo_i = lowest(src_lo & 32'h3DFF_FFFE & m0lo);
    hi_i = lowest(hi_view(src_hi, gcause) & 32'h1F00_03F7 & m0hi);
    gp_i = lowest(gcause & gmask);
    if (lo_i >= 0) begin e_valid = 1; e_vec = lo_i; end
    else if (hi_i >= 24 && hi_i <= 27) begin
      if (gp_i >= 0) begin e_valid = 1; e_vec = 64 + gp_i; end
      else e_spur = 1;
    end else if (hi_i >= 0) begin e_valid = 1; e_vec = 32 + hi_i; end
    check({tag, " R6 valid"}, {31'b0, vvalid}, {31'b0, e_valid});
    check({tag, " R7 spurious"}, {31'b0, vspur}, {31'b0, e_spur});
    if (e_valid) check({tag, " R1 vector"}, {25'b0, vnum}, e_vec);
    check({tag, " R12 cpu0"}, {31'b0, cpu0}, {31'b0, e_valid | e_spur});
    check({tag, " R9 cpu1"}, {31'b0, cpu1}, {31'b0, src_lo[28] & m1lo[28]});
    check({tag, " R10 rdata"}, rdata, read_model(addr));
  endtask

  // One clock: drive on falling edge, update model at rising edge, sample 1 ns later
  task automatic cycle(string tag, logic [31:0] lo, logic [31:0] hi, logic [31:0] p,
                       logic w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    src_lo = lo; src_hi = hi; pin = p; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (w) begin
      case (a)
        5'h08: m0lo = d;
        5'h0C: m0hi = d;
        5'h10: m1lo = d;
        5'h18: gmask = d;
        default: ;
      endcase
    end
    gcause = (gcause & ((w && a == 5'h14) ? d : 32'hFFFF_FFFF)) | p;
    check_outputs(tag);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    addr = 5'h0C;
    src_lo = 32'hFFFF_FFFF;
    #9;
    // R5: reset state
    check("R5 high mask reset", rdata, 32'h0F00_0000);
    check("R5 no vector", {31'b0, vvalid}, 32'h0);
    rst_n = 1'b1;
    cycle("R5", '0, '0, '0, 0, 5'h08, '0);
    cycle("R5", '0, '0, '0, 0, 5'h10, '0);
    cycle("R5", '0, '0, '0, 0, 5'h14, '0);
    cycle("R5", '0, '0, '0, 0, 5'h18, '0);
    check("R5 gpp cause zero", rdata, 32'h0);

    // R3: disallowed low bits never win
    cycle("R3", '0, '0, '0, 1, 5'h08, 32'hFFFF_FFFF);
    cycle("R3", 32'hC200_0001, '0, '0, 0, 5'h00, '0);
    check("R3 ignored low bits", {31'b0, cpu0}, 32'h0);
    // R6: lowest enabled low bit wins, low beats high
    cycle("R6", 32'h0000_0F00, 32'h0000_0001, '0, 0, 5'h04, '0);
    check("R6 low first", {25'b0, vnum}, 32'd8);

    // R4: disallowed high bits never win
    cycle("R4", '0, '0, '0, 1, 5'h08, '0);
    cycle("R4", '0, '0, '0, 1, 5'h0C, 32'hFFFF_FFFF);
    cycle("R4", '0, 32'hE0FF_FC08, '0, 0, 5'h04, '0);
    check("R4 ignored high bits", {31'b0, cpu0}, 32'h0);
    // R11: src_hi 24..27 ignored, summary from pin cause
    cycle("R11", '0, 32'h0F00_0000, '0, 0, 5'h04, '0);
    check("R11 summary bits", rdata, 32'h0F00_0000 & 32'h0000_0000);
    cycle("R1", '0, 32'h0000_0010, '0, 0, 5'h04, '0);
    check("R1 high vector", {25'b0, vnum}, 32'd36);

    // R7: summary wins without enabled pin cause
    cycle("R2", '0, '0, 32'h0000_0200, 0, 5'h14, '0);
    check("R2 pin cause set", rdata, 32'h0000_0200);
    cycle("R7", '0, '0, '0, 0, 5'h04, '0);
    check("R11 summary group1", rdata, 32'h0200_0000);
    check("R7 spurious", {31'b0, vspur}, 32'h1);
    cycle("R1", '0, '0, '0, 1, 5'h18, 32'h0000_0300);
    check("R1 gpp vector", {25'b0, vnum}, 32'd73);
    // R8: write-one keeps, write-zero clears
    cycle("R8", '0, '0, 32'h0000_0100, 1, 5'h14, 32'hFFFF_FFFF);
    check("R8 ones keep", rdata, 32'h0000_0300);
    cycle("R8", '0, '0, '0, 1, 5'h14, 32'hFFFF_FEFF);
    check("R8 zero clears", rdata, 32'h0000_0200);
    cycle("R8", '0, '0, '0, 1, 5'h14, 32'h0);
    check("R8 all clear", {31'b0, cpu0}, 32'h0);

    // R9: doorbell only
    cycle("R9", 32'hEFFF_FFFF, '0, '0, 1, 5'h10, 32'hFFFF_FFFF);
    check("R9 non-doorbell", {31'b0, cpu1}, 32'h0);
    cycle("R9", 32'h1000_0000, '0, '0, 0, 5'h1C, '0);
    check("R9 doorbell", {31'b0, cpu1}, 32'h1);
    check("R10 unmapped read", rdata, 32'h0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] lo, hi, p, d;
      logic        w;
      logic [4:0]  a;
      lo = $urandom & $urandom & $urandom & $urandom;
      hi = $urandom & $urandom & $urandom;
      p  = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom & $urandom) : '0;
      w  = ($urandom % 3 == 0);
      a  = 5'(($urandom % 7) * 4);
      d  = (a == 5'h14) ? ~($urandom & $urandom) : $urandom;
      cycle("rand R1 R2 R6", lo, hi, p, w, a, d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule